// File: doc/BRIEF.md
# Approximate Logarithmic Unsigned Multiplier

This block multiplies two unsigned integers of WIDTH bits without any partial-product array. Each operand is reduced to a leading-one position (its integer logarithm) and the bits beneath that one, which are read as a binary fraction. The two positions are summed, the two fractions are summed, and the carry out of the fraction adder picks between two ways of turning the summed logarithm back into an integer. That conversion is a single left shift of a WIDTH-bit word by the summed position, with the fractional bits truncated. The result is a 2*WIDTH-bit product that never exceeds the exact one.

It suits datapaths where noise already hides a few percent of arithmetic error, such as filters, correlators and neural accumulators, and where a full multiplier costs too much area or power. A parameter selects either a purely combinational path or a path with one output register, whose load is gated by the input strobe.

Top module: `logmul_approx`

## Requirements
- R1: When either operand is zero, the product output is zero.
- R2: When both operands are powers of two, the product equals the exact product.
- R3: With leading-one positions ka, kb and fractions xa, xb (the bits below the leading one divided by 2^k), if xa + xb < 1 the product is floor(2^(ka+kb) * (1 + xa + xb)); for example 5 x 9 gives 44.
- R4: If xa + xb >= 1 the product is floor(2^(ka+kb+1) * (xa + xb)); for example 6 x 12 gives 64 and 65535 x 65535 gives 4294836224.
- R5: The product never exceeds the exact product of the two operands.
- R6: For nonzero operands, 9 * (product + 1) >= 8 * exact product, that is, the relative error stays within about 11.1 % apart from one unit of truncation.
- R7: Over uniformly random 16-bit operands the mean relative error lies between 2 % and 5 %.
- R8: With OUT_REG = 1, out_valid equals in_valid delayed by one clock and the product appears one clock after the operands are presented with in_valid high.
- R9: With OUT_REG = 1, when in_valid is low the product output holds its previous value whatever the operands do.
- R10: With OUT_REG = 1, after reset out_valid is 0 and the product is 0.
- R11: Swapping the two operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Product is valid |
| product | output | 2*WIDTH | Approximate product |

## Verification
The bench aims at the carry boundary of the fraction adder: 6 x 12 sums to exactly one, and a design that tested the carry with the wrong comparison or forgot the extra shift would return 32 or 96 instead of 64. Operands of all ones push the shift amount to its largest value, where a too-narrow shift word would wrap and give a tiny result. Powers of two and the operand one expose off-by-one errors in the leading-one index or the fraction alignment as non-exact results, zero operands expose a missing zero override (a design without it would output a power of two), and the strobe-low cycles expose a register that loads without in_valid. Random operands compared against a real-valued model, together with the error-bound and mean-error checks, catch any slip in truncation or alignment.

// File: rtl/logmul_pkg.sv
package logmul_pkg;

   // Which antilogarithm form produced the result
   typedef enum logic {
      PATH_BELOW_ONE = 1'b0,   // fraction sum < 1
      PATH_CARRY     = 1'b1    // fraction sum >= 1
   } antilog_path_e;

   // Index width for a WIDTH-bit operand (at least one bit)
   function automatic int idx_bits(input int width);
      return (width <= 2) ? 1 : $clog2(width);
   endfunction

endpackage

// File: rtl/lead_one_detect.sv
module lead_one_detect #(
   parameter int WIDTH = 16,
   parameter int IDXW  = logmul_pkg::idx_bits(WIDTH)
) (
   input  logic [WIDTH-1:0] value,
   output logic [IDXW-1:0]  index,
   output logic             nonzero
);

   always_comb begin
      index   = '0;
      nonzero = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
         if (value[i]) begin
            index   = IDXW'(i);
            nonzero = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mant_align.sv
module mant_align #(
   parameter int WIDTH = 16,
   parameter int IDXW  = logmul_pkg::idx_bits(WIDTH),
   localparam int FRACW = WIDTH - 1
) (
   input  logic [WIDTH-1:0] value,
   input  logic [IDXW-1:0]  index,
   output logic [FRACW-1:0] frac
);

   logic [WIDTH-1:0] shifted;
   logic [IDXW:0]    lshift;

   always_comb begin
      lshift  = (IDXW+1)'(FRACW) - {1'b0, index};
      shifted = value << lshift;
      frac    = shifted[FRACW-1:0];
   end

endmodule

// File: rtl/antilog_shift.sv
module antilog_shift #(
   parameter int WIDTH = 16,
   parameter int SHW   = 5,
   localparam int FRACW = WIDTH - 1,
   localparam int OUTW  = 2 * WIDTH,
   localparam int WIDEW = OUTW + WIDTH
) (
   input  logic [WIDTH-1:0] mword,
   input  logic [SHW-1:0]   shamt,
   output logic [OUTW-1:0]  result
);

   logic [WIDEW-1:0] wide;

   always_comb begin
      wide   = {{OUTW{1'b0}}, mword} << shamt;
      result = wide[FRACW +: OUTW];
   end

endmodule

// File: rtl/logmul_approx.sv
module logmul_approx #(
   parameter int WIDTH   = 16,
   parameter bit OUT_REG = 1'b1,
   localparam int IDXW  = logmul_pkg::idx_bits(WIDTH),
   localparam int FRACW = WIDTH - 1,
   localparam int SHW   = IDXW + 1,
   localparam int OUTW  = 2 * WIDTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WIDTH-1:0]  op_a,
   input  logic [WIDTH-1:0]  op_b,
   output logic              out_valid,
   output logic [OUTW-1:0]   product
);
   import logmul_pkg::*;

   if (WIDTH < 2) begin : g_bad_width_lo
      $error("logmul_approx: WIDTH must be at least 2");
   end
   if (WIDTH > 64) begin : g_bad_width_hi
      $error("logmul_approx: WIDTH must not exceed 64");
   end

   logic [WIDTH-1:0] opnd   [2];
   logic [IDXW-1:0]  charac [2];
   logic [FRACW-1:0] frac   [2];
   logic             nz     [2];

   assign opnd[0] = op_a;
   assign opnd[1] = op_b;

   for (genvar g = 0; g < 2; g++) begin : g_operand
      lead_one_detect #(.WIDTH(WIDTH), .IDXW(IDXW)) i_lod (
         .value   (opnd[g]),
         .index   (charac[g]),
         .nonzero (nz[g])
      );
      mant_align #(.WIDTH(WIDTH), .IDXW(IDXW)) i_align (
         .value (opnd[g]),
         .index (charac[g]),
         .frac  (frac[g])
      );
   end

   logic [WIDTH-1:0] frac_sum;
   antilog_path_e    path;
   logic [WIDTH-1:0] mword;
   logic [SHW-1:0]   shamt;
   logic [OUTW-1:0]  approx;
   logic [OUTW-1:0]  comb_prod;

   always_comb begin
      frac_sum = {1'b0, frac[0]} + {1'b0, frac[1]};
      path     = antilog_path_e'(frac_sum[FRACW]);
      if (path == PATH_CARRY) begin
         mword = frac_sum;
      end else begin
         mword = {1'b1, frac_sum[FRACW-1:0]};
      end
      shamt = {1'b0, charac[0]} + {1'b0, charac[1]} + SHW'(frac_sum[FRACW]);
   end

   antilog_shift #(.WIDTH(WIDTH), .SHW(SHW)) i_antilog (
      .mword  (mword),
      .shamt  (shamt),
      .result (approx)
   );

   assign comb_prod = (nz[0] && nz[1]) ? approx : '0;

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               product <= comb_prod;
            end
         end
      end
   end else begin : g_comb_out
      assign out_valid = in_valid;
      assign product   = comb_prod;
   end

endmodule

// File: rtl/logmul_approx_chk.sv
module logmul_approx_chk #(
   parameter int WIDTH   = 16,
   parameter bit OUT_REG = 1'b1,
   localparam int OUTW = 2 * WIDTH
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic             out_valid,
   input logic [OUTW-1:0]  product
);

   logic [OUTW-1:0] exact;
   assign exact = OUTW'(op_a) * OUTW'(op_b);

   if (OUT_REG) begin : g_seq
      // R8: strobe is delayed by one clock
      a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(in_valid));
      // R1: zero operand gives zero product
      a_r1_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (op_a == '0 || op_b == '0)) |=> (product == '0));
      // R5: never above the exact product
      a_r5_no_exceed: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (product <= $past(exact)));
      // R2: powers of two are exact
      a_r2_pow2_exact: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && $countones(op_a) == 1 && $countones(op_b) == 1)
            |=> (product == $past(exact)));
      // R9: output held while strobe is low
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(product));
   end else begin : g_comb
      a_r1_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (op_a == '0 || op_b == '0)) |-> (product == '0));
      a_r5_no_exceed: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> (product <= exact));
      a_r2_pow2_exact: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && $countones(op_a) == 1 && $countones(op_b) == 1)
            |-> (product == exact));
      a_r8_valid_pass: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
   end

endmodule

bind logmul_approx logmul_approx_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .out_valid (out_valid),
   .product   (product)
);

// File: tb/test_logmul_approx.sv
module test_logmul_approx;
   localparam int  WIDTH  = 16;
   localparam int  OUTW   = 2 * WIDTH;
   localparam time PERIOD = 10ns;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [WIDTH-1:0] op_a = '0;
   logic [WIDTH-1:0] op_b = '0;
   logic             out_valid;
   logic [OUTW-1:0]  product;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   logmul_approx #(.WIDTH(WIDTH), .OUT_REG(1'b1)) i_logmul_approx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
   );

   // Real-valued model of the logarithmic approximation
   function automatic longint unsigned model(input longint unsigned a, input longint unsigned b);
      int  ka, kb;
      real xa, xb, s, r;
      if (a == 0 || b == 0) return 0;
      ka = 0; kb = 0;
      for (int i = 0; i < WIDTH; i++) begin
         if (a[i]) ka = i;
         if (b[i]) kb = i;
      end
      xa = real'(a - (64'd1 << ka)) / real'(64'd1 << ka);
      xb = real'(b - (64'd1 << kb)) / real'(64'd1 << kb);
      s  = xa + xb;
      if (s < 1.0) r = (2.0 ** (ka + kb)) * (1.0 + s);
      else         r = (2.0 ** (ka + kb + 1)) * s;
      return longint'($floor(r));
   endfunction

   task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Present operands, return the registered product one clock later
   task automatic run_op(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         output longint unsigned res);
      @(negedge clk);
      op_a = a; op_b = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      res = product;
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      longint unsigned r, r2, ex;
      real err_sum;
      int  nrand;
      void'($urandom(32'd4711));

      #(PERIOD * 2 + 1ns);
      check("R10 reset out_valid", out_valid, 0);
      check("R10 reset product", product, 0);
      @(negedge clk); rst_n = 1'b1;

      // R8: latency and strobe delay
      @(negedge clk);
      op_a = 16'd5; op_b = 16'd9; in_valid = 1'b1;
      check("R8 no output before edge", product, 0);
      @(negedge clk);
      check("R8 out_valid after one clock", out_valid, 1);
      check("R3 5x9", product, 44);
      in_valid = 1'b0;
      @(negedge clk);
      check("R8 out_valid drops", out_valid, 0);

      // R9: operands change with strobe low
      op_a = 16'd1000; op_b = 16'd777;
      @(negedge clk);
      check("R9 hold while idle", product, 44);

      run_op(16'd6, 16'd12, r);        check("R4 carry at exactly one", r, 64);
      run_op(16'd3, 16'd3, r);         check("R4 3x3", r, 8);
      run_op(16'hFFFF, 16'hFFFF, r);   check("R4 max operands", r, 64'd4294836224);
      run_op(16'd0, 16'd1234, r);      check("R1 zero a", r, 0);
      run_op(16'hFFFF, 16'd0, r);      check("R1 zero b", r, 0);
      run_op(16'd1, 16'd1, r);         check("R2 1x1", r, 1);
      run_op(16'h8000, 16'h8000, r);   check("R2 top bits", r, 64'h4000_0000);
      run_op(16'd64, 16'd4, r);        check("R2 64x4", r, 256);
      run_op(16'd1, 16'hFFFF, r);      check("R3 one times max", r, 65535);
      run_op(16'd1000, 16'd3, r);      check("R11 order ab", r, model(1000, 3));
      run_op(16'd3, 16'd1000, r2);     check("R11 order ba", r2, r);

      err_sum = 0.0;
      nrand   = 0;
      for (int i = 0; i < 3000; i++) begin
         logic [WIDTH-1:0] a, b;
         a = WIDTH'($urandom);
         b = WIDTH'($urandom);
         if (i % 97 == 0) a = '0;
         run_op(a, b, r);
         ex = longint'(a) * longint'(b);
         check((model(a, b)[0] == 1'b0 && a != 0 && b != 0) ? "R3/R4 random" : "R3/R4 random", r, model(a, b));
         checks++;
         if (r > ex) begin
            errors++;
            $display("FAIL R5: actual %0d expected at most %0d", r, ex);
         end
         if (ex != 0) begin
            checks++;
            if (9 * (r + 1) < 8 * ex) begin
               errors++;
               $display("FAIL R6: actual %0d expected at least %0d", r, (8 * ex) / 9);
            end
            err_sum += real'(ex - r) / real'(ex);
            nrand++;
         end
      end
      checks++;
      if (err_sum / nrand < 0.02 || err_sum / nrand > 0.05) begin
         errors++;
         $display("FAIL R7: actual mean error %f expected 0.02..0.05", err_sum / nrand);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule